// File: doc/BRIEF.md
# Input Capture and Pulse Measurement

This block timestamps transitions of asynchronous digital inputs against a shared free-running count and derives the period and high time of each input. Each channel has its own input, a three-bit mode selector, and four result registers: the count at the last captured rising edge, the count at the last captured falling edge, the last measured period and the last measured high time. Each capture is marked by a one-cycle event pulse.

Beside the capture logic sits a per-channel slice of event flags with matching interrupt enables. Each channel owns four flag bits: one for reload, one for capture and two for compare. The reload and compare events come in from a neighbouring counter block. Flags are cleared by writing ones. The interrupt line is high while any enabled flag is set.

Top module: `ic_capture_top`

## Requirements
- R1: After reset every result register, every flag, every interrupt enable, every event pulse and the interrupt line read zero.
- R2: Mode 1 captures on rising edges only. The count present at the third rising clock edge after the input changes is loaded into the channel's rising-edge register. Falling edges leave the falling-edge register unchanged.
- R3: Mode 2 captures on falling edges only. The count is loaded into the falling-edge register. Rising edges leave the rising-edge register unchanged.
- R4: Mode 3 captures on both edges. Each edge writes its own register.
- R5: Mode 4 also records both edges. On a rising edge the period register takes the count minus the previous rising-edge capture, modulo 2^CNT_W. On a falling edge the high-time register takes the count minus the latest rising-edge capture.
- R6: Mode 0 and the unused codes 5 to 7 capture nothing. They raise no event and no capture flag, and all four result registers keep their values.
- R7: Every captured edge produces a `cap_evt` pulse lasting one cycle. One cycle later it sets the channel's capture flag at bit ch*4+1.
- R8: `reload_evt[ch]` sets flag bit ch*4. `cmp_evt[ch*2+n]` sets flag bit ch*4+2+n.
- R9: A cycle with `clr_wr` high clears each flag whose `clr_data` bit is 1. Flags whose `clr_data` bit is 0 are unchanged.
- R10: If a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R11: `ien_wr` loads `ien_data` into the interrupt enables, which use the flag bit positions. `irq` is high exactly when some flag is set and its enable is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count | input | CNT_W | Free-running timer count to be timestamped |
| mode | input | NUM_CH*3 | Per-channel capture mode, channel ch at bits ch*3+2:ch*3 |
| sig_in | input | NUM_CH | Asynchronous signals under test |
| reload_evt | input | NUM_CH | Reload event pulses from the counter |
| cmp_evt | input | NUM_CH*2 | Compare event pulses, comparator n of channel ch at bit ch*2+n |
| clr_wr | input | 1 | Write strobe for clearing flags |
| clr_data | input | NUM_CH*4 | Ones select the flags to clear |
| ien_wr | input | 1 | Write strobe for the interrupt enables |
| ien_data | input | NUM_CH*4 | New interrupt enable value |
| cap_rise | output | NUM_CH*CNT_W | Rising-edge captures |
| cap_fall | output | NUM_CH*CNT_W | Falling-edge captures |
| meas_period | output | NUM_CH*CNT_W | Measured periods |
| meas_high | output | NUM_CH*CNT_W | Measured high times |
| cap_evt | output | NUM_CH | Capture event pulse per channel |
| status | output | NUM_CH*4 | Event flags |
| irq_en | output | NUM_CH*4 | Interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the reload and compare inputs are pulses in the clock domain. They also assume that the mode of a channel is stable in the cycle before each result update is judged, which follows from mode changes being rare software writes. The stimulus changes mode only while the input under test is idle. It holds `count` constant for the few cycles between an input transition and its capture, so each expected timestamp is a single known value. Input transitions are spaced several cycles apart, so the two-flop synchroniser never sees a pulse shorter than a clock.

// File: rtl/ic_pkg.sv
package ic_pkg;

  typedef enum logic [2:0] {
    CAPM_OFF   = 3'd0,
    CAPM_RISE  = 3'd1,
    CAPM_FALL  = 3'd2,
    CAPM_BOTH  = 3'd3,
    CAPM_WIDTH = 3'd4
  } capm_e;

  localparam int FLAGS_PER_CH = 4;
  localparam int OFS_RELOAD   = 0;
  localparam int OFS_CAPTURE  = 1;
  localparam int OFS_COMPARE  = 2;
  localparam int CMP_PER_CH   = 2;
  localparam int MODE_W       = 3;

  function automatic logic mode_takes_rise(logic [MODE_W-1:0] m);
    return (m == CAPM_RISE) || (m == CAPM_BOTH) || (m == CAPM_WIDTH);
  endfunction

  function automatic logic mode_takes_fall(logic [MODE_W-1:0] m);
    return (m == CAPM_FALL) || (m == CAPM_BOTH) || (m == CAPM_WIDTH);
  endfunction

endpackage

// File: rtl/ic_edge_sync.sv
module ic_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/ic_capture_chan.sv
module ic_capture_chan
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic [MODE_W-1:0] mode,
  input  logic              rise,
  input  logic              fall,
  output logic [CNT_W-1:0]  cap_rise,
  output logic [CNT_W-1:0]  cap_fall,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  high,
  output logic              evt
);
  logic             take_r, take_f, width_m;
  logic             upd_rise, upd_fall, upd_per, upd_high;
  logic [CNT_W-1:0] rise_q, fall_q, per_q, high_q;
  logic [CNT_W-1:0] rise_d, fall_d, per_d, high_d;
  logic [CNT_W-1:0] since_rise;
  logic             evt_q, evt_d;

  always_comb begin
    take_r     = rise & mode_takes_rise(mode);
    take_f     = fall & mode_takes_fall(mode);
    width_m    = (mode == CAPM_WIDTH);
    since_rise = count - rise_q;
    upd_rise   = take_r;
    upd_fall   = take_f;
    upd_per    = take_r & width_m;
    upd_high   = take_f & width_m;
    rise_d     = count;
    fall_d     = count;
    per_d      = since_rise;
    high_d     = since_rise;
    evt_d      = take_r | take_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      per_q  <= '0;
      high_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (upd_rise) rise_q <= rise_d;
      if (upd_fall) fall_q <= fall_d;
      if (upd_per)  per_q  <= per_d;
      if (upd_high) high_q <= high_d;
      evt_q <= evt_d;
    end
  end

  assign cap_rise = rise_q;
  assign cap_fall = fall_q;
  assign period   = per_q;
  assign high     = high_q;
  assign evt      = evt_q;
endmodule

// File: rtl/ic_flag_bank.sv
module ic_flag_bank
  import ic_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CH*FLAGS_PER_CH-1:0] set_vec,
  input  logic                           clr_wr,
  input  logic [NUM_CH*FLAGS_PER_CH-1:0] clr_data,
  input  logic                           ien_wr,
  input  logic [NUM_CH*FLAGS_PER_CH-1:0] ien_data,
  output logic [NUM_CH*FLAGS_PER_CH-1:0] status,
  output logic [NUM_CH*FLAGS_PER_CH-1:0] ien,
  output logic                           irq
);
  localparam int FLAG_W = NUM_CH * FLAGS_PER_CH;

  logic [FLAG_W-1:0] sts_q, sts_d, ien_q, ien_d, clr_mask;
  logic              sts_en;

  always_comb begin
    clr_mask = clr_wr ? clr_data : '0;
    sts_en   = clr_wr | (|set_vec);
    // set is applied after the clear so a coincident event survives
    sts_d    = (sts_q & ~clr_mask) | set_vec;
    ien_d    = ien_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      if (sts_en) sts_q <= sts_d;
      if (ien_wr) ien_q <= ien_d;
    end
  end

  assign status = sts_q;
  assign ien    = ien_q;
  assign irq    = |(sts_q & ien_q);
endmodule

// File: rtl/ic_capture_top.sv
module ic_capture_top
  import ic_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CNT_W-1:0]               count,
  input  logic [NUM_CH*MODE_W-1:0]       mode,
  input  logic [NUM_CH-1:0]              sig_in,
  input  logic [NUM_CH-1:0]              reload_evt,
  input  logic [NUM_CH*CMP_PER_CH-1:0]   cmp_evt,
  input  logic                           clr_wr,
  input  logic [NUM_CH*FLAGS_PER_CH-1:0] clr_data,
  input  logic                           ien_wr,
  input  logic [NUM_CH*FLAGS_PER_CH-1:0] ien_data,
  output logic [NUM_CH*CNT_W-1:0]        cap_rise,
  output logic [NUM_CH*CNT_W-1:0]        cap_fall,
  output logic [NUM_CH*CNT_W-1:0]        meas_period,
  output logic [NUM_CH*CNT_W-1:0]        meas_high,
  output logic [NUM_CH-1:0]              cap_evt,
  output logic [NUM_CH*FLAGS_PER_CH-1:0] status,
  output logic [NUM_CH*FLAGS_PER_CH-1:0] irq_en,
  output logic                           irq
);
  localparam int FLAG_W = NUM_CH * FLAGS_PER_CH;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  logic [NUM_CH-1:0] rise_w, fall_w, evt_w;
  logic [FLAG_W-1:0] set_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ic_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .async_in (sig_in[c]),
      .rise     (rise_w[c]),
      .fall     (fall_w[c])
    );

    ic_capture_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .count    (count),
      .mode     (mode[c*MODE_W +: MODE_W]),
      .rise     (rise_w[c]),
      .fall     (fall_w[c]),
      .cap_rise (cap_rise[c*CNT_W +: CNT_W]),
      .cap_fall (cap_fall[c*CNT_W +: CNT_W]),
      .period   (meas_period[c*CNT_W +: CNT_W]),
      .high     (meas_high[c*CNT_W +: CNT_W]),
      .evt      (evt_w[c])
    );

    assign set_vec[c*FLAGS_PER_CH + OFS_RELOAD]  = reload_evt[c];
    assign set_vec[c*FLAGS_PER_CH + OFS_CAPTURE] = evt_w[c];
    for (genvar n = 0; n < CMP_PER_CH; n++) begin : g_cmp
      assign set_vec[c*FLAGS_PER_CH + OFS_COMPARE + n] = cmp_evt[c*CMP_PER_CH + n];
    end
  end

  assign cap_evt = evt_w;

  ic_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .set_vec  (set_vec),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .ien_wr   (ien_wr),
    .ien_data (ien_data),
    .status   (status),
    .ien      (irq_en),
    .irq      (irq)
  );
endmodule

// File: rtl/ic_capture_chk.sv
module ic_capture_chk
  import ic_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CH*MODE_W-1:0]       mode,
  input logic [NUM_CH-1:0]              cap_evt,
  input logic [NUM_CH*CNT_W-1:0]        cap_rise,
  input logic [NUM_CH*CNT_W-1:0]        cap_fall,
  input logic [NUM_CH-1:0]              reload_evt,
  input logic                           clr_wr,
  input logic [NUM_CH*FLAGS_PER_CH-1:0] clr_data,
  input logic [NUM_CH*FLAGS_PER_CH-1:0] status,
  input logic [NUM_CH*FLAGS_PER_CH-1:0] irq_en,
  input logic                           irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam int RB = c*FLAGS_PER_CH + OFS_RELOAD;
    localparam int CB = c*FLAGS_PER_CH + OFS_CAPTURE;

    a_r6_off_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[c*MODE_W +: MODE_W] == CAPM_OFF) |=> !cap_evt[c]);

    a_r2_rise_keeps_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[c*MODE_W +: MODE_W] == CAPM_RISE) |=> $stable(cap_fall[c*CNT_W +: CNT_W]));

    a_r3_fall_keeps_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[c*MODE_W +: MODE_W] == CAPM_FALL) |=> $stable(cap_rise[c*CNT_W +: CNT_W]));

    a_r7_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[c] |=> status[CB]);

    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      reload_evt[c] |=> status[RB]);

    a_r9_zero_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (status[RB] && !(clr_wr && clr_data[RB])) |=> status[RB]);

    a_r9_one_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_data[RB] && !reload_evt[c]) |=> !status[RB]);
  end

  a_r11_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0 || status == '0) |-> !irq);
endmodule

bind ic_capture_top ic_capture_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .mode       (mode),
  .cap_evt    (cap_evt),
  .cap_rise   (cap_rise),
  .cap_fall   (cap_fall),
  .reload_evt (reload_evt),
  .clr_wr     (clr_wr),
  .clr_data   (clr_data),
  .status     (status),
  .irq_en     (irq_en),
  .irq        (irq)
);

// File: tb/test_ic_capture_top.sv
module test_ic_capture_top;
  localparam int NC = 2;
  localparam int W  = 16;
  localparam int FW = NC*4;

  logic            clk, rst_n;
  logic [W-1:0]    count;
  logic [NC*3-1:0] mode;
  logic [NC-1:0]   sig_in, reload_evt;
  logic [NC*2-1:0] cmp_evt;
  logic            clr_wr, ien_wr;
  logic [FW-1:0]   clr_data, ien_data;
  logic [NC*W-1:0] cap_rise, cap_fall, meas_period, meas_high;
  logic [NC-1:0]   cap_evt;
  logic [FW-1:0]   status, irq_en;
  logic            irq;

  ic_capture_top #(.NUM_CH(NC), .CNT_W(W)) i_ic_capture_top (
    .clk(clk), .rst_n(rst_n), .count(count), .mode(mode), .sig_in(sig_in),
    .reload_evt(reload_evt), .cmp_evt(cmp_evt), .clr_wr(clr_wr), .clr_data(clr_data),
    .ien_wr(ien_wr), .ien_data(ien_data), .cap_rise(cap_rise), .cap_fall(cap_fall),
    .meas_period(meas_period), .meas_high(meas_high), .cap_evt(cap_evt),
    .status(status), .irq_en(irq_en), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    int           ch;
    string        req;
    logic [W-1:0] r, f, p, h;
  } item_t;
  item_t sb[$];

  // bench model of the results and flags
  logic [W-1:0]  m_rise [NC];
  logic [W-1:0]  m_fall [NC];
  logic [W-1:0]  m_per  [NC];
  logic [W-1:0]  m_high [NC];
  logic [2:0]    m_mode [NC];
  logic [FW-1:0] m_sts;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every capture pulse pops one expected item
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++) begin
        if (cap_evt[c] === 1'b1) begin
          if (sb.size() == 0) begin
            chk("R7 unexpected capture event", 32'(c), 32'hFFFF);
          end else begin
            item_t it;
            it = sb.pop_front();
            chk({it.req, " event channel"}, 32'(c), 32'(it.ch));
            chk({it.req, " rise reg"},   32'(cap_rise[c*W +: W]),    32'(it.r));
            chk({it.req, " fall reg"},   32'(cap_fall[c*W +: W]),    32'(it.f));
            chk({it.req, " period reg"}, 32'(meas_period[c*W +: W]), 32'(it.p));
            chk({it.req, " high reg"},   32'(meas_high[c*W +: W]),   32'(it.h));
          end
        end
      end
    end
  end

  task automatic set_mode(int ch, logic [2:0] m);
    @(negedge clk);
    mode[ch*3 +: 3] = m;
    m_mode[ch] = m;
  endtask

  task automatic check_regs(int ch, string req);
    chk({req, " rise reg held"},   32'(cap_rise[ch*W +: W]),    32'(m_rise[ch]));
    chk({req, " fall reg held"},   32'(cap_fall[ch*W +: W]),    32'(m_fall[ch]));
    chk({req, " period reg held"}, 32'(meas_period[ch*W +: W]), 32'(m_per[ch]));
    chk({req, " high reg held"},   32'(meas_high[ch*W +: W]),   32'(m_high[ch]));
  endtask

  // driver: move one input, push the expected capture, wait it out
  task automatic drive_edge(int ch, logic lvl, logic [W-1:0] cnt, string req);
    logic  r, f, tr, tf;
    logic [2:0] m;
    item_t it;
    @(negedge clk);
    count = cnt;
    m  = m_mode[ch];
    r  = lvl & ~sig_in[ch];
    f  = ~lvl & sig_in[ch];
    tr = r && (m == 3'd1 || m == 3'd3 || m == 3'd4);
    tf = f && (m == 3'd2 || m == 3'd3 || m == 3'd4);
    if (tr) begin
      if (m == 3'd4) m_per[ch] = cnt - m_rise[ch];
      m_rise[ch] = cnt;
    end
    if (tf) begin
      if (m == 3'd4) m_high[ch] = cnt - m_rise[ch];
      m_fall[ch] = cnt;
    end
    if (tr || tf) begin
      it.ch = ch; it.req = req;
      it.r = m_rise[ch]; it.f = m_fall[ch]; it.p = m_per[ch]; it.h = m_high[ch];
      sb.push_back(it);
      m_sts[ch*4+1] = 1'b1;
    end
    sig_in[ch] = lvl;
    repeat (6) @(negedge clk);
    chk({req, " R7 pending captures"}, 32'(sb.size()), 32'd0);
    check_regs(ch, req);
    chk({req, " R7 flags"}, 32'(status), 32'(m_sts));
  endtask

  task automatic clear_flags(logic [FW-1:0] msk);
    @(negedge clk);
    clr_wr = 1'b1; clr_data = msk;
    @(negedge clk);
    clr_wr = 1'b0; clr_data = '0;
    m_sts = m_sts & ~msk;
  endtask

  initial begin
    rst_n = 1'b1; count = '0; mode = '0; sig_in = '0; reload_evt = '0; cmp_evt = '0;
    clr_wr = 1'b0; clr_data = '0; ien_wr = 1'b0; ien_data = '0;
    for (int c = 0; c < NC; c++) begin
      m_rise[c] = '0; m_fall[c] = '0; m_per[c] = '0; m_high[c] = '0; m_mode[c] = '0;
    end
    m_sts = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 status", 32'(status), 0);
    chk("R1 irq_en", 32'(irq_en), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cap_evt", 32'(cap_evt), 0);
    chk("R1 rise regs", 32'(cap_rise), 0);
    chk("R1 fall regs", 32'(cap_fall), 0);
    chk("R1 period regs", 32'(meas_period), 0);
    chk("R1 high regs", 32'(meas_high), 0);

    // R2 rising only
    set_mode(0, 3'd1);
    drive_edge(0, 1'b1, 16'h0100, "R2 rise capture");
    drive_edge(0, 1'b0, 16'h0150, "R2 fall ignored");

    // R3 falling only
    set_mode(0, 3'd2);
    drive_edge(0, 1'b1, 16'h0200, "R3 rise ignored");
    drive_edge(0, 1'b0, 16'h0230, "R3 fall capture");

    // R4 both edges
    set_mode(0, 3'd3);
    drive_edge(0, 1'b1, 16'h0300, "R4 rise capture");
    drive_edge(0, 1'b0, 16'h0345, "R4 fall capture");

    // R6 disabled and reserved codes
    clear_flags(8'h02);
    set_mode(0, 3'd0);
    drive_edge(0, 1'b1, 16'h0400, "R6 off rise");
    drive_edge(0, 1'b0, 16'h0410, "R6 off fall");
    set_mode(0, 3'd5);
    drive_edge(0, 1'b1, 16'h0500, "R6 code5 rise");
    drive_edge(0, 1'b0, 16'h0510, "R6 code5 fall");
    set_mode(0, 3'd7);
    drive_edge(0, 1'b1, 16'h0600, "R6 code7 rise");
    drive_edge(0, 1'b0, 16'h0610, "R6 code7 fall");

    // R5 period and high time on channel 1, including wrap
    set_mode(1, 3'd4);
    drive_edge(1, 1'b1, 16'h1000, "R5 first rise");
    drive_edge(1, 1'b0, 16'h1030, "R5 high 0x30");
    drive_edge(1, 1'b1, 16'h1100, "R5 period 0x100");
    drive_edge(1, 1'b0, 16'h1120, "R5 high 0x20");
    drive_edge(1, 1'b1, 16'h0010, "R5 period wrap");
    drive_edge(1, 1'b0, 16'h0015, "R5 high after wrap");

    // R8 flag positions
    clear_flags('1);
    @(negedge clk);
    reload_evt[1] = 1'b1;
    @(negedge clk);
    reload_evt[1] = 1'b0;
    chk("R8 reload ch1 -> bit4", 32'(status), 32'h10);
    @(negedge clk);
    cmp_evt[3] = 1'b1; cmp_evt[0] = 1'b1;
    @(negedge clk);
    cmp_evt = '0;
    chk("R8 compare bits 7 and 2", 32'(status), 32'h94);
    m_sts = 8'h94;

    // R9 selective clear
    clear_flags(8'h10);
    chk("R9 clear bit4 keeps others", 32'(status), 32'h84);
    clear_flags(8'h00);
    chk("R9 zero write keeps flags", 32'(status), 32'h84);

    // R10 set and clear collide on bit0
    @(negedge clk);
    reload_evt[0] = 1'b1; clr_wr = 1'b1; clr_data = 8'h05;
    @(negedge clk);
    reload_evt[0] = 1'b0; clr_wr = 1'b0; clr_data = '0;
    chk("R10 set wins, bit2 cleared", 32'(status), 32'h81);

    // R11 interrupt enables
    chk("R11 no irq with no enables", 32'(irq), 0);
    @(negedge clk);
    ien_wr = 1'b1; ien_data = 8'h02;
    @(negedge clk);
    ien_wr = 1'b0;
    chk("R11 enable readback", 32'(irq_en), 32'h02);
    chk("R11 enabled bit not set", 32'(irq), 0);
    @(negedge clk);
    ien_wr = 1'b1; ien_data = 8'h80;
    @(negedge clk);
    ien_wr = 1'b0;
    chk("R11 irq from bit7", 32'(irq), 1);
    clear_flags(8'h80);
    chk("R11 irq drops after clear", 32'(irq), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule